// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two signed operands of `W` bits. A format select input picks how all three numbers (both operands and the result) are encoded: two's complement, one's complement or sign-magnitude. Each format uses its own arithmetic rule:

- **Two's complement:** the carry out of the top bit is dropped.
- **One's complement:** the carry out of the top bit is wrapped back into the least significant bit.
- **Sign-magnitude:** magnitudes are added when the signs agree. When the signs differ, the larger magnitude minus the smaller is taken, with the sign of the larger.

A surrounding datapath presents one operation with `in_valid` high. One clock later the block shows the registered result, an overflow flag and a negative-zero flag, with `out_valid` high for that cycle. The registered outputs keep their values until the next valid operation.

Top module: `addsub_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, `overflow`, `neg_zero` and `out_valid` become 0.
- R2: An operation accepted with `in_valid` high appears on the outputs after the next rising edge, with `out_valid` high for exactly that one cycle.
- R3: While `in_valid` is low, `result`, `overflow` and `neg_zero` hold their values.
- R4: Two's complement (`fmt` = 2'b00) addition adds the encodings and drops the carry out of bit W-1.
- R5: Two's complement overflow is 1 exactly when the carry into bit W-1 differs from the carry out of it. Adding operands of opposite sign therefore never overflows.
- R6: With `op_sub` = 1 in either complement format, the subtrahend is negated in that format (bit inversion, plus one for two's complement) and then added.
- R7: One's complement (`fmt` = 2'b01) adds the carry out of bit W-1 back into the sum (end-around carry).
- R8: One's complement overflow is 1 when both addends (after any negation) have the same sign bit and the wrapped sum has the other sign bit.
- R9: Sign-magnitude (`fmt` = 2'b10; bit W-1 is the sign, 1 meaning negative) with equal effective signs adds the magnitudes and keeps the common sign. `op_sub` inverts the sign of B.
- R10: Sign-magnitude with unequal effective signs subtracts the smaller magnitude from the larger and takes the sign of the larger. A zero difference is returned as positive zero (all bits 0).
- R11: Sign-magnitude overflow is 1 when the magnitude sum carries out of the W-1 magnitude bits. The result then holds the common sign and the low W-1 bits of that sum.
- R12: `neg_zero` is 1 when the result is the negative-zero encoding of its format: 1 followed by zeros in sign-magnitude, all ones in one's complement. It is never set in two's complement.
- R13: `fmt` = 2'b11 behaves exactly as two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | W | Operand A (minuend for subtraction) |
| op_b | input | W | Operand B (subtrahend for subtraction) |
| op_sub | input | 1 | 1 = A - B, 0 = A + B |
| fmt | input | 2 | Number format: 00 two's, 01 one's, 10 sign-magnitude, 11 as two's |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | W | Registered sum or difference |
| overflow | output | 1 | Result is outside the range of the format |
| neg_zero | output | 1 | Result is the negative-zero encoding |

## Verification
Every result, flag and `out_valid` is due one rising edge after the cycle in which `in_valid` was high, because one register stage separates the inputs from the outputs. The bench changes inputs on falling edges and reads the outputs on the falling edge after the capturing rising edge, which is half a period clear of any update. For the hold and pulse checks it reads the outputs again one and two falling edges later with `in_valid` low, while the operands are changed under it.

// File: rtl/addsub_pkg.sv
// Package: shared format encoding for the multi-format adder/subtractor.
// Assumes every module that decodes the format imports this package.
package addsub_pkg;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'b00,
        FMT_ONES = 2'b01,
        FMT_SMAG = 2'b10,
        FMT_ALT  = 2'b11
    } num_fmt_e;

endpackage

// File: rtl/addsub_cmp_path.sv
// Module: complement-format adder.
// Handles both two's complement (carry out discarded) and one's complement
// (end-around carry) arithmetic. A subtraction negates B in the chosen format.
// Assumes W >= 2. Purely combinational.
module addsub_cmp_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         ones_mode,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         nz
);

    logic [W-1:0] b_x;
    logic         cin;
    logic [W:0]   raw;
    logic [W-1:0] wrap;
    logic         c_into;
    logic         c_out;

    // Form the effective addend and the carry-in used for two's negation.
    always_comb begin
        b_x = sub ? ~b : b;
        cin = sub & ~ones_mode;
    end

    // Plain sum plus the one's complement wrap of its carry.
    always_comb begin
        raw    = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, cin};
        c_out  = raw[W];
        c_into = raw[W-1] ^ a[W-1] ^ b_x[W-1];
        wrap   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end

    // Pick the format result and its flags.
    always_comb begin
        if (ones_mode) begin
            res = wrap;
            ovf = (a[W-1] == b_x[W-1]) && (wrap[W-1] != a[W-1]);
            nz  = &wrap;
        end else begin
            res = raw[W-1:0];
            ovf = c_into ^ c_out;
            nz  = 1'b0;
        end
    end

endmodule

// File: rtl/addsub_smag_path.sv
// Module: sign-magnitude adder.
// Equal effective signs add the magnitudes. Unequal signs subtract the smaller
// from the larger, and the result takes the sign of the larger. A zero
// difference is forced to positive zero. Assumes W >= 2. Purely combinational.
module addsub_smag_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         nz
);

    localparam int MW = W - 1;
    localparam logic [W-1:0] NEG_ZERO = {1'b1, {MW{1'b0}}};

    logic          sa;
    logic          sb;
    logic [MW-1:0] ma;
    logic [MW-1:0] mb;
    logic [MW:0]   msum;
    logic [MW-1:0] mdiff;
    logic          a_ge;
    logic          dsign;

    // Split the operands; a subtraction flips the sign of B.
    always_comb begin
        sa = a[W-1];
        sb = b[W-1] ^ sub;
        ma = a[MW-1:0];
        mb = b[MW-1:0];
    end

    // Magnitude sum, and the ordered magnitude difference.
    always_comb begin
        msum  = {1'b0, ma} + {1'b0, mb};
        a_ge  = (ma >= mb);
        mdiff = a_ge ? (ma - mb) : (mb - ma);
        dsign = (mdiff == '0) ? 1'b0 : (a_ge ? sa : sb);
    end

    // Choose between the add and compare-subtract cases.
    always_comb begin
        if (sa == sb) begin
            res = {sa, msum[MW-1:0]};
            ovf = msum[MW];
        end else begin
            res = {dsign, mdiff};
            ovf = 1'b0;
        end
        nz = (res == NEG_ZERO);
    end

endmodule

// File: rtl/addsub_unit.sv
// Module: top of the multi-format signed adder/subtractor.
// Selects the complement or sign-magnitude path by format and registers the
// result and flags one cycle after a valid input. Outputs hold between valid
// inputs. Synchronous active-low reset. Assumes W >= 2.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_sub,
    input  logic [1:0]   fmt,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         overflow,
    output logic         neg_zero
);

    num_fmt_e     fmt_e;
    logic         use_smag;
    logic         ones_mode;
    logic [W-1:0] c_res;
    logic         c_ovf;
    logic         c_nz;
    logic [W-1:0] s_res;
    logic         s_ovf;
    logic         s_nz;
    logic [W-1:0] nxt_res;
    logic         nxt_ovf;
    logic         nxt_nz;

    // Decode the format select; the spare code behaves as two's complement.
    always_comb begin
        fmt_e = num_fmt_e'(fmt);
        unique case (fmt_e)
            FMT_ONES: begin ones_mode = 1'b1; use_smag = 1'b0; end
            FMT_SMAG: begin ones_mode = 1'b0; use_smag = 1'b1; end
            default:  begin ones_mode = 1'b0; use_smag = 1'b0; end
        endcase
    end

    addsub_cmp_path #(.W(W)) u_cmp (
        .a         (op_a),
        .b         (op_b),
        .sub       (op_sub),
        .ones_mode (ones_mode),
        .res       (c_res),
        .ovf       (c_ovf),
        .nz        (c_nz)
    );

    addsub_smag_path #(.W(W)) u_smag (
        .a   (op_a),
        .b   (op_b),
        .sub (op_sub),
        .res (s_res),
        .ovf (s_ovf),
        .nz  (s_nz)
    );

    // Route the active path to the output register.
    always_comb begin
        nxt_res = use_smag ? s_res : c_res;
        nxt_ovf = use_smag ? s_ovf : c_ovf;
        nxt_nz  = use_smag ? s_nz  : c_nz;
    end

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            neg_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= nxt_res;
                overflow <= nxt_ovf;
                neg_zero <= nxt_nz;
            end
        end
    end

endmodule

// File: rtl/addsub_chk.sv
// Module: assertion checker bound to addsub_unit.
// Observes the ports only. Assumes the synchronous active-low reset.
module addsub_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         a_msb,
    input logic         b_msb,
    input logic         op_sub,
    input logic [1:0]   fmt,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         neg_zero
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !overflow && !neg_zero));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(overflow) && $stable(neg_zero)));

    // R5
    mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b00 && !op_sub && (a_msb != b_msb)) |=> !overflow);

    // R12
    twos_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (fmt == 2'b00 || fmt == 2'b11)) |=> !neg_zero);

    // R12
    smag_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b10) |=> (neg_zero == (result == {1'b1, {(W-1){1'b0}}})));

endmodule

bind addsub_unit addsub_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_msb     (op_a[W-1]),
    .b_msb     (op_b[W-1]),
    .op_sub    (op_sub),
    .fmt       (fmt),
    .out_valid (out_valid),
    .result    (result),
    .overflow  (overflow),
    .neg_zero  (neg_zero)
);

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;

    localparam int W  = 8;
    localparam int NV = 23;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         op_sub = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic         out_valid;
    logic [W-1:0] result;
    logic         overflow;
    logic         neg_zero;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    addsub_unit #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sub    (op_sub),
        .fmt       (fmt),
        .out_valid (out_valid),
        .result    (result),
        .overflow  (overflow),
        .neg_zero  (neg_zero)
    );

    // Vector layout: fmt[28:27] sub[26] a[25:18] b[17:10] res[9:2] ovf[1] nz[0]
    localparam logic [28:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'h05, 8'h03, 8'h08, 1'b0, 1'b0},  // R4
        {2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, 1'b0},  // R5
        {2'b00, 1'b0, 8'h80, 8'hFF, 8'h7F, 1'b1, 1'b0},  // R4
        {2'b00, 1'b1, 8'h05, 8'h07, 8'hFE, 1'b0, 1'b0},  // R6
        {2'b00, 1'b1, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0},  // R5
        {2'b00, 1'b1, 8'hFB, 8'hFB, 8'h00, 1'b0, 1'b0},  // R6
        {2'b01, 1'b0, 8'hFC, 8'hFB, 8'hF8, 1'b0, 1'b0},  // R7
        {2'b01, 1'b1, 8'hFC, 8'hFB, 8'h01, 1'b0, 1'b0},  // R6
        {2'b01, 1'b0, 8'h05, 8'hFA, 8'hFF, 1'b0, 1'b1},  // R12
        {2'b01, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, 1'b0},  // R8
        {2'b01, 1'b0, 8'h81, 8'hFE, 8'h80, 1'b0, 1'b0},  // R7
        {2'b01, 1'b0, 8'h80, 8'hFE, 8'h7F, 1'b1, 1'b0},  // R8
        {2'b10, 1'b0, 8'h05, 8'h03, 8'h08, 1'b0, 1'b0},  // R9
        {2'b10, 1'b0, 8'h85, 8'h83, 8'h88, 1'b0, 1'b0},  // R9
        {2'b10, 1'b0, 8'h05, 8'h87, 8'h82, 1'b0, 1'b0},  // R10
        {2'b10, 1'b0, 8'h87, 8'h05, 8'h82, 1'b0, 1'b0},  // R10
        {2'b10, 1'b0, 8'h05, 8'h85, 8'h00, 1'b0, 1'b0},  // R10
        {2'b10, 1'b0, 8'h7F, 8'h01, 8'h00, 1'b1, 1'b0},  // R11
        {2'b10, 1'b1, 8'h03, 8'h05, 8'h82, 1'b0, 1'b0},  // R9
        {2'b10, 1'b1, 8'h85, 8'h05, 8'h8A, 1'b0, 1'b0},  // R9
        {2'b10, 1'b0, 8'h80, 8'h80, 8'h80, 1'b0, 1'b1},  // R12
        {2'b10, 1'b1, 8'h80, 8'h00, 8'h80, 1'b0, 1'b1},  // R12
        {2'b11, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, 1'b0}   // R13
    };

    localparam string TAG [NV] = '{
        "R4", "R5", "R4", "R6", "R5", "R6",
        "R7", "R6", "R12", "R8", "R7", "R8",
        "R9", "R9", "R10", "R10", "R10", "R11", "R9", "R9", "R12", "R12",
        "R13"
    };

    task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] f, input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        fmt = f; op_sub = s; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear during reset
        check("R1", {out_valid, overflow, neg_zero, result}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Walk the vector table; outputs are due one edge after the valid cycle.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][28:27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
            check(TAG[i], {out_valid, overflow, neg_zero, result},
                  {1'b1, VEC[i][1], VEC[i][0], VEC[i][9:2]});
        end

        // R2 and R3: pulse ends and outputs hold while operands change
        apply(2'b01, 1'b0, 8'h05, 8'hFA);
        op_a = 8'h11; op_b = 8'h22; fmt = 2'b00;
        @(negedge clk);
        check("R2", {2'b00, 1'b0, out_valid}, {2'b00, 1'b0, 1'b0});
        check("R3", {out_valid, overflow, neg_zero, result}, {1'b0, 1'b0, 1'b1, 8'hFF});
        @(negedge clk);
        check("R3", {out_valid, overflow, neg_zero, result}, {1'b0, 1'b0, 1'b1, 8'hFF});

        // R2: back-to-back operations each produce a result one edge later
        fmt = 2'b00; op_sub = 1'b0; op_a = 8'h01; op_b = 8'h01; in_valid = 1'b1;
        @(negedge clk);
        check("R2", {out_valid, overflow, neg_zero, result}, {1'b1, 1'b0, 1'b0, 8'h02});
        op_a = 8'h10;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {out_valid, overflow, neg_zero, result}, {1'b1, 1'b0, 1'b0, 8'h11});

        // R1: reset in mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, overflow, neg_zero, result}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule